// File: doc/BRIEF.md
# Thermometer-to-Binary Output Encoder

This block sits behind a bank of 255 comparators and turns their thermometer vector into an 8-bit code. A comparator whose threshold lies below the input level reads 1, and one above it reads 0. The encoder counts the ones, so the code runs from 0 for an empty vector to 255 for a full one. An input past either end of the range gives the matching full-scale code and never wraps. Counting ones also keeps a stray misplaced bit (a bubble) from producing a code far from the true level.

Two active-low format pins flip bits of the code before it reaches the output register. `msb_flip_n` flips only bit 7. `low_flip_n` flips only bits 6 to 0. With both pins high the output is offset binary. With both low it is inverted binary. With only the MSB flipped it is twos complement. With only the low bits flipped it is inverted twos complement.

A convert strobe drives a two-stage pipeline. On each rising edge of the strobe the first stage samples the encoded level, and the second stage loads the formatted version of the previous sample. Data sampled on strobe N therefore reaches the output at strobe N+1. The output then holds its value until the next strobe.

Top module: `thermo_encoder`

## Requirements
- R1: A synchronous active-high reset clears both pipeline stages, so the output reads 0x00 after reset.
- R2: With both format pins high, a thermometer vector whose lowest k bits are 1 and the rest 0 produces output code k, for every k from 0 to 255.
- R3: An all-zero vector yields 0x00 and an all-ones vector yields 0xFF in offset binary, with no wrap at either end.
- R4: When `msb_flip_n` is low, output bit 7 is the inverse of the offset-binary bit 7; when it is high, bit 7 is unchanged.
- R5: When `low_flip_n` is low, output bits 6..0 are the inverse of the offset-binary bits 6..0; when it is high, they are unchanged.
- R6: With `msb_flip_n` low and `low_flip_n` high, level 127 reads 0xFF and level 128 reads 0x00 (twos complement). With both pins low, every bit of the code is inverted.
- R7: The vector is sampled only on a 0-to-1 transition of `conv_i`, observed at a clock edge. Holding `conv_i` high does not resample.
- R8: The output holds its value between strobes. A vector sampled on strobe N appears on `data_o` right after strobe N+1 and not after strobe N.
- R9: A vector with misplaced bits encodes to its count of ones. For example, level 200 with bit 50 cleared gives 199.
- R10: The format pins act only when a strobe loads the output register. A change on the pins between strobes leaves `data_o` unchanged, and the next strobe applies the new format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_i | input | 1 | Convert strobe; a rising edge advances the pipeline |
| therm_i | input | 255 | Comparator thermometer vector, bit 0 is the lowest threshold |
| msb_flip_n | input | 1 | Active-low control that inverts output bit 7 |
| low_flip_n | input | 1 | Active-low control that inverts output bits 6..0 |
| data_o | output | 8 | Registered output code |

## Verification
Every clean thermometer level from 0 to 255 is converted under each of the four pin combinations. This separates a wrong count from a wrong bit flip. The sweep runs levels in rising order so the one-strobe latency is checked on every step. Levels 127/128 and the two full-scale vectors pin down the twos-complement midpoint and the no-wrap rule. Vectors with a cleared bit below the top, or an isolated bit above it, show that misplaced bits shift the code by one count and no more. Runs that change the vector, hold the strobe high or toggle the format pins without a new strobe show that the output register loads only on a strobe edge.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    localparam int CODE_W = 8;

    typedef enum logic {
        ENC_ONES_COUNT = 1'b0,
        ENC_TOP_ONE    = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic flip_msb;
        logic flip_low;
    } fmt_ctrl_t;

    function automatic fmt_ctrl_t ctrl_from_pins(input logic msb_n, input logic low_n);
        fmt_ctrl_t c;
        c.flip_msb = ~msb_n;
        c.flip_low = ~low_n;
        return c;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strb_i,
    output logic fire_o
);
    logic strb_q;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb_i;
    end

    assign fire_o = strb_i & ~strb_q;
endmodule

// File: rtl/thermo_count.sv
module thermo_count #(
    parameter int                    WIDTH = thermo_pkg::CODE_W,
    parameter thermo_pkg::enc_mode_e MODE  = thermo_pkg::ENC_ONES_COUNT,
    localparam int                   LEVELS = (1 << WIDTH) - 1
) (
    input  logic [LEVELS-1:0] therm_i,
    output logic [WIDTH-1:0]  level_o
);
    generate
        if (MODE == thermo_pkg::ENC_ONES_COUNT) begin : g_count
            always_comb begin
                level_o = '0;
                for (int i = 0; i < LEVELS; i++)
                    level_o = level_o + WIDTH'(therm_i[i]);
            end
        end else begin : g_top
            always_comb begin
                level_o = '0;
                for (int i = 0; i < LEVELS; i++)
                    if (therm_i[i]) level_o = WIDTH'(i + 1);
            end
        end
    endgenerate
endmodule

// File: rtl/code_format.sv
module code_format #(
    parameter int WIDTH = thermo_pkg::CODE_W
) (
    input  logic [WIDTH-1:0]          code_i,
    input  thermo_pkg::fmt_ctrl_t     ctrl_i,
    output logic [WIDTH-1:0]          code_o
);
    logic [WIDTH-1:0] flip_mask;

    assign flip_mask = {ctrl_i.flip_msb, {(WIDTH-1){ctrl_i.flip_low}}};
    assign code_o    = code_i ^ flip_mask;
endmodule

// File: rtl/thermo_encoder.sv
module thermo_encoder #(
    parameter int                    WIDTH  = thermo_pkg::CODE_W,
    parameter thermo_pkg::enc_mode_e MODE   = thermo_pkg::ENC_ONES_COUNT,
    localparam int                   LEVELS = (1 << WIDTH) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_i,
    input  logic [LEVELS-1:0] therm_i,
    input  logic              msb_flip_n,
    input  logic              low_flip_n,
    output logic [WIDTH-1:0]  data_o
);
    import thermo_pkg::*;

    logic             fire;
    logic [WIDTH-1:0] level_w;
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] fmt_w;
    logic [WIDTH-1:0] data_q;
    fmt_ctrl_t        ctrl;

    assign ctrl = ctrl_from_pins(msb_flip_n, low_flip_n);

    strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strb_i (conv_i),
        .fire_o (fire)
    );

    thermo_count #(.WIDTH(WIDTH), .MODE(MODE)) u_count (
        .therm_i (therm_i),
        .level_o (level_w)
    );

    code_format #(.WIDTH(WIDTH)) u_fmt (
        .code_i (level_q),
        .ctrl_i (ctrl),
        .code_o (fmt_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            data_q  <= '0;
        end else if (fire) begin
            level_q <= level_w;
            data_q  <= fmt_w;
        end
    end

    assign data_o = data_q;
endmodule

// File: rtl/thermo_encoder_chk.sv
module thermo_encoder_chk #(
    parameter int  WIDTH  = thermo_pkg::CODE_W,
    localparam int LEVELS = (1 << WIDTH) - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_i,
    input logic [LEVELS-1:0] therm_i,
    input logic [WIDTH-1:0]  level,
    input logic [WIDTH-1:0]  data_o
);
    logic rst_q;
    logic conv_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        conv_q <= rst ? 1'b0 : conv_i;
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (data_o == '0)
                else $error("R1: output not cleared by reset");
        end
    end

    a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !(conv_i && !conv_q) |=> $stable(data_o))
        else $error("R8: output changed without a strobe edge");

    a_r7_no_resample_high: assert property (@(posedge clk) disable iff (rst)
        (conv_i && conv_q) |=> $stable(data_o))
        else $error("R7: held strobe resampled");

    a_r3_full_scale_top: assert property (@(posedge clk) disable iff (rst)
        (&therm_i) |-> (level == '1))
        else $error("R3: all-ones vector not full scale");

    a_r3_full_scale_bottom: assert property (@(posedge clk) disable iff (rst)
        (therm_i == '0) |-> (level == '0))
        else $error("R3: all-zero vector not zero");
endmodule

bind thermo_encoder thermo_encoder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .conv_i (conv_i),
    .therm_i(therm_i),
    .level  (level_w),
    .data_o (data_o)
);

// File: tb/thermo_encoder_tb.sv
`timescale 1ns/1ps
module thermo_encoder_tb;
    localparam int W = 8;
    localparam int L = 255;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv = 1'b0;
    logic [L-1:0] therm = '0;
    logic         msb_n = 1'b1;
    logic         lsb_n = 1'b1;
    logic [W-1:0] data;

    int errors = 0;
    int checks = 0;
    int last_lvl = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermo_encoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .conv_i     (conv),
        .therm_i    (therm),
        .msb_flip_n (msb_n),
        .low_flip_n (lsb_n),
        .data_o     (data)
    );

    function automatic logic [L-1:0] therm_of(input int k);
        logic [L-1:0] v;
        for (int i = 0; i < L; i++) v[i] = (i < k);
        return v;
    endfunction

    function automatic logic [W-1:0] model(input int k, input logic mn, input logic ln);
        logic [W-1:0] c;
        c = W'(k);
        if (!mn) c[7] = ~c[7];
        if (!ln) c[6:0] = ~c[6:0];
        return c;
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) conv = 1'b1;
        @(negedge clk) conv = 1'b0;
    endtask

    task automatic convert_vec(input logic [L-1:0] v, input int lvl, input string req);
        logic [W-1:0] exp;
        exp = model(last_lvl, msb_n, lsb_n);
        @(negedge clk) therm = v;
        strobe();
        check(data, exp, req);
        last_lvl = lvl;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(data, 8'h00, "R1 reset");
        last_lvl = 0;
    endtask

    task automatic t_sweep(input logic mn, input logic ln, input string req);
        @(negedge clk) begin msb_n = mn; lsb_n = ln; end
        for (int k = 0; k <= 255; k++) convert_vec(therm_of(k), k, req);
        convert_vec(therm_of(0), 0, req);
    endtask

    task automatic t_extremes();
        @(negedge clk) begin msb_n = 1'b1; lsb_n = 1'b1; end
        convert_vec('1, 255, "R3 prime");
        convert_vec('0, 0, "R3 all ones -> FF");
        convert_vec('1, 255, "R3 all zeros -> 00");
        convert_vec('0, 0, "R3 all ones again -> FF");
    endtask

    task automatic t_twos();
        @(negedge clk) begin msb_n = 1'b0; lsb_n = 1'b1; end
        convert_vec(therm_of(127), 127, "R6 prime");
        convert_vec(therm_of(128), 128, "R6 level127");
        check(data, 8'hFF, "R6 level127 twos");
        convert_vec(therm_of(0), 0, "R6 level128");
        check(data, 8'h00, "R6 level128 twos");
        @(negedge clk) begin msb_n = 1'b0; lsb_n = 1'b0; end
        convert_vec(therm_of(5), 5, "R6 inverted prime");
        convert_vec(therm_of(0), 0, "R6 inverted");
        check(data, 8'hFA, "R6 full invert of 5");
    endtask

    task automatic t_latency_hold();
        logic [W-1:0] held;
        @(negedge clk) begin msb_n = 1'b1; lsb_n = 1'b1; end
        convert_vec(therm_of(10), 10, "R8 prime");
        convert_vec(therm_of(77), 77, "R8 not yet");
        check(data, 8'd10, "R8 previous sample shown");
        held = data;
        @(negedge clk) therm = therm_of(200);
        repeat (6) @(negedge clk);
        check(data, held, "R8 hold without strobe");
        @(negedge clk) conv = 1'b1;
        repeat (6) @(negedge clk);
        check(data, 8'd77, "R7 first edge of held strobe");
        check(data, 8'd77, "R7 no resample while high");
        @(negedge clk) therm = therm_of(30);
        repeat (3) @(negedge clk);
        check(data, 8'd77, "R7 still no resample");
        @(negedge clk) conv = 1'b0;
        last_lvl = 200;
        convert_vec(therm_of(0), 0, "R8 after held strobe");
        check(data, 8'd200, "R8 level sampled on held edge");
    endtask

    task automatic t_bubble();
        logic [L-1:0] v;
        @(negedge clk) begin msb_n = 1'b1; lsb_n = 1'b1; end
        v = therm_of(200);
        v[50] = 1'b0;
        convert_vec(v, 199, "R9 prime");
        v = therm_of(10);
        v[250] = 1'b1;
        convert_vec(v, 11, "R9 cleared bit");
        check(data, 8'd199, "R9 cleared bit count");
        convert_vec(therm_of(0), 0, "R9 isolated bit");
        check(data, 8'd11, "R9 isolated bit count");
    endtask

    task automatic t_ctrl_change();
        @(negedge clk) begin msb_n = 1'b1; lsb_n = 1'b1; end
        convert_vec(therm_of(3), 3, "R10 prime");
        convert_vec(therm_of(3), 3, "R10 base");
        check(data, 8'h03, "R10 base value");
        @(negedge clk) begin msb_n = 1'b0; lsb_n = 1'b0; end
        repeat (4) @(negedge clk);
        check(data, 8'h03, "R10 pins change without strobe");
        convert_vec(therm_of(3), 3, "R10 applied on next strobe");
        check(data, 8'hFC, "R10 new format");
    endtask

    initial begin
        t_reset();
        t_sweep(1'b1, 1'b1, "R2 offset binary");
        t_sweep(1'b0, 1'b1, "R4 msb flip");
        t_sweep(1'b1, 1'b0, "R5 low flip");
        t_sweep(1'b0, 1'b0, "R6 both flip");
        t_extremes();
        t_twos();
        t_latency_hold();
        t_bubble();
        t_ctrl_change();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule